// File: doc/BRIEF.md
# Character display parallel host interface

This block is the slave side of the parallel bus by which a host reaches a character display controller. The host drives a register-select line, a read/write line and an enable strobe. It moves bytes over an 8-bit data bus that the block drives only while a read is in progress. Each complete access falls into one of four kinds, chosen by the register-select and read/write levels. These are an instruction write, a status read that returns a busy flag and the address counter, a data write, and a data read. For each completed access the block gives the internal logic a single-cycle strobe.

The enable input is asynchronous to the core clock and is synchronised inside the block. Register select and read/write are taken at the detected rising enable. The data byte is the last value seen on the bus while enable was high, and it is committed at the detected falling enable. A mode input selects full 8-bit transfers or 4-bit transfers. In 4-bit mode each byte takes two enable cycles on data lines 7 to 4, high nibble first. After an accepted write the busy flag stays set for a run-time programmable number of clock cycles. The internal logic cannot stall the block, so every strobe must be taken in the cycle it appears. The only flow control is the busy flag, which the host reads back. When the host uses another access path, it holds enable low and the block stays idle.

Top module: `lcd_host_if`

## Requirements
- R1: After reset no strobe is asserted, db_oe_o is 0, busy_o is 0 and the nibble phase is at the high half.
- R2: An access with rs_i=0 and rw_i=0 ends in one pulse on instr_wr_o, with wr_byte_o equal to the byte written.
- R3: An access with rs_i=1 and rw_i=0 ends in one pulse on data_wr_o, with wr_byte_o equal to the byte written. This holds even while busy_o is 1.
- R4: An access with rs_i=0 and rw_i=1 presents {busy, ac_i[6:0]} on db_o while enable is high, with the busy flag in bit 7. It ends in one pulse on status_rd_o.
- R5: An access with rs_i=1 and rw_i=1 presents rd_data_i on db_o while enable is high and ends in one pulse on data_rd_o.
- R6: db_oe_o is 1 only during a read access while enable is high, and it is 0 once the falling enable has been processed.
- R7: With nib_mode_i=1 a byte takes two enable cycles. The first carries bits 7:4 on db_i[7:4] and the second carries bits 3:0 on db_i[7:4]. db_i[3:0] is ignored, and one strobe is issued per byte.
- R8: A read in nibble mode presents the high nibble of the read byte on db_o[7:4] in the first enable cycle and the low nibble in the second, with db_o[3:0]=0.
- R9: Any change of nib_mode_i returns the nibble phase to the high half and discards a half-received byte.
- R10: An accepted instruction write or data write keeps busy_o at 1 for exactly busy_len_i clock cycles, starting in the cycle of its strobe.
- R11: An instruction write that completes while busy_o is 1 gives one pulse on instr_err_o instead of instr_wr_o and does not restart the busy count.
- R12: While en_i is held low, no strobe is asserted, whatever rs_i, rw_i and db_i do.
- R13: At most one of the five strobes is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| en_i | input | 1 | Asynchronous transfer strobe |
| nib_mode_i | input | 1 | 1 selects 4-bit transfers on lines 7:4 |
| db_i | input | 8 | Data bus as seen at the pins |
| db_o | output | 8 | Data bus drive value during reads |
| db_oe_o | output | 1 | Data bus output enable |
| ac_i | input | 7 | Address counter from the internal logic |
| rd_data_i | input | 8 | Byte returned on data reads |
| busy_len_i | input | 8 | Busy duration in clock cycles after a write |
| busy_o | output | 1 | Busy flag |
| instr_wr_o | output | 1 | Instruction write strobe |
| data_wr_o | output | 1 | Data write strobe |
| status_rd_o | output | 1 | Status read completed |
| data_rd_o | output | 1 | Data read completed |
| instr_err_o | output | 1 | Instruction write rejected while busy |
| wr_byte_o | output | 8 | Byte for the write strobes |

## Verification
The hardest state to reach is an instruction write that completes while the busy count is still running. A second complete access has to fit inside the busy window. The bench sets a busy length longer than one status read plus one write. It then issues a write, a status read that must show bit 7 set, and a second instruction write that must be rejected. Because the busy-cycle tally stays at the programmed length, the rejected write cannot have restarted the count. The nibble-phase reset is reached by sending half a byte, flipping the mode and returning, and then checking that the next two nibbles form exactly one byte.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int AC_W   = DATA_W - 1;

  // encoding is {register select, read/write}
  typedef enum logic [1:0] {
    ACC_IWR  = 2'b00,
    ACC_STAT = 2'b01,
    ACC_DWR  = 2'b10,
    ACC_DRD  = 2'b11
  } acc_e;
endpackage

// File: rtl/lcd_en_sync.sv
module lcd_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic en_lvl,
  output logic en_rise,
  output logic en_fall
);
  logic [STAGES-1:0] chain;
  logic              lvl_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= en_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= chain[STAGES-1];
  end

  assign en_lvl  = chain[STAGES-1];
  assign en_rise = chain[STAGES-1] & ~lvl_q;
  assign en_fall = ~chain[STAGES-1] & lvl_q;
endmodule

// File: rtl/lcd_nibble_asm.sv
module lcd_nibble_asm
  import lcd_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nib_mode,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              done,
  output logic [DATA_W-1:0] byte_o,
  output logic              phase
);
  logic             mode_q;
  logic [NIB_W-1:0] hi_q;
  logic             mode_chg;

  assign mode_chg = nib_mode ^ mode_q;

  always_comb begin
    done   = 1'b0;
    byte_o = din;
    if (take && !mode_chg) begin
      if (!nib_mode) begin
        done = 1'b1;
      end else if (phase) begin
        done   = 1'b1;
        byte_o = {hi_q, din[DATA_W-1 -: NIB_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      hi_q   <= '0;
      phase  <= 1'b0;
    end else begin
      mode_q <= nib_mode;
      if (mode_chg) begin
        phase <= 1'b0;
        hi_q  <= '0;
      end else if (take && nib_mode) begin
        if (!phase) hi_q <= din[DATA_W-1 -: NIB_W];
        phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= len;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic              en_i,
  input  logic              nib_mode_i,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] db_o,
  output logic              db_oe_o,
  input  logic [AC_W-1:0]   ac_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [BUSY_W-1:0] busy_len_i,
  output logic              busy_o,
  output logic              instr_wr_o,
  output logic              data_wr_o,
  output logic              status_rd_o,
  output logic              data_rd_o,
  output logic              instr_err_o,
  output logic [DATA_W-1:0] wr_byte_o
);
  logic              en_lvl, en_rise, en_fall;
  acc_e              acc_q;
  logic [DATA_W-1:0] samp_q;
  logic [DATA_W-1:0] rd_byte_q;
  logic              rd_act_q;
  logic              done, phase;
  logic [DATA_W-1:0] asm_byte;
  logic              tmr_load;

  lcd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .en_lvl(en_lvl), .en_rise(en_rise), .en_fall(en_fall)
  );

  lcd_nibble_asm u_asm (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode_i), .take(en_fall),
    .din(samp_q), .done(done), .byte_o(asm_byte), .phase(phase)
  );

  lcd_busy_timer #(.CNT_W(BUSY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(busy_len_i), .busy(busy_o)
  );

  // access framing: type at rise, bus value tracked while enable is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_IWR;
      samp_q    <= '0;
      rd_byte_q <= '0;
      rd_act_q  <= 1'b0;
    end else begin
      if (en_lvl) samp_q <= db_i;
      if (en_rise) begin
        acc_q    <= acc_e'({rs_i, rw_i});
        rd_act_q <= rw_i;
        // a byte is latched once, on its first enable cycle
        if (rw_i && !(nib_mode_i && phase))
          rd_byte_q <= rs_i ? rd_data_i : {busy_o, ac_i};
      end else if (en_fall) begin
        rd_act_q <= 1'b0;
      end
    end
  end

  // read drive
  always_comb begin
    if (!nib_mode_i)  db_o = rd_byte_q;
    else if (!phase)  db_o = {rd_byte_q[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
    else              db_o = {rd_byte_q[NIB_W-1:0], {NIB_W{1'b0}}};
  end
  assign db_oe_o = rd_act_q;

  // completion decode
  logic iwr_ok, iwr_bad, dwr_go, stat_go, drd_go;
  always_comb begin
    iwr_ok  = done && (acc_q == ACC_IWR) && !busy_o;
    iwr_bad = done && (acc_q == ACC_IWR) &&  busy_o;
    dwr_go  = done && (acc_q == ACC_DWR);
    stat_go = done && (acc_q == ACC_STAT);
    drd_go  = done && (acc_q == ACC_DRD);
  end
  assign tmr_load = iwr_ok | dwr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_wr_o  <= 1'b0;
      data_wr_o   <= 1'b0;
      status_rd_o <= 1'b0;
      data_rd_o   <= 1'b0;
      instr_err_o <= 1'b0;
      wr_byte_o   <= '0;
    end else begin
      instr_wr_o  <= iwr_ok;
      data_wr_o   <= dwr_go;
      status_rd_o <= stat_go;
      data_rd_o   <= drd_go;
      instr_err_o <= iwr_bad;
      if (iwr_ok || dwr_go) wr_byte_o <= asm_byte;
    end
  end
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
  parameter int BUSY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_lvl,
  input logic              en_fall,
  input logic              db_oe_o,
  input logic              busy_o,
  input logic              instr_wr_o,
  input logic              data_wr_o,
  input logic              status_rd_o,
  input logic              data_rd_o,
  input logic              instr_err_o,
  input logic [BUSY_W-1:0] busy_len_i
);
  logic any_strobe;
  assign any_strobe = instr_wr_o | data_wr_o | status_rd_o | data_rd_o | instr_err_o;

  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_wr_o, data_wr_o, status_rd_o, data_rd_o, instr_err_o}));

  a_r12_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> $past(en_fall));

  a_r6_oe_within_enable: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe_o |-> (en_lvl || en_fall));

  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !db_oe_o);

  a_r10_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((instr_wr_o || data_wr_o) && ($past(busy_len_i) != '0)) |-> busy_o);

  a_r10_no_write_at_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !(instr_wr_o || data_wr_o));

  a_r11_err_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    instr_err_o |-> $past(busy_o));
endmodule

bind lcd_host_if lcd_host_if_chk #(.BUSY_W(BUSY_W)) chk_i (.*);

// File: tb/lcd_host_if_tb.sv
module lcd_host_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rs_i = 1'b0, rw_i = 1'b0, en_i = 1'b0, nib_mode_i = 1'b0;
  logic [7:0] db_i = '0;
  logic [7:0] db_o;
  logic       db_oe_o;
  logic [6:0] ac_i = '0;
  logic [7:0] rd_data_i = '0;
  logic [7:0] busy_len_i = '0;
  logic       busy_o, instr_wr_o, data_wr_o, status_rd_o, data_rd_o, instr_err_o;
  logic [7:0] wr_byte_o;

  int tests = 0, fails = 0;
  int n_iwr = 0, n_dwr = 0, n_stat = 0, n_drd = 0, n_err = 0, n_busy = 0;
  logic [7:0] last_wr = '0;
  logic       last_oe;

  always #4 clk = ~clk;

  lcd_host_if dut_i (.*);

  always @(negedge clk) begin
    if (instr_wr_o)  begin n_iwr++; last_wr = wr_byte_o; end
    if (data_wr_o)   begin n_dwr++; last_wr = wr_byte_o; end
    if (status_rd_o) n_stat++;
    if (data_rd_o)   n_drd++;
    if (instr_err_o) n_err++;
    if (busy_o)      n_busy++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] v, output logic [7:0] r);
    @(negedge clk);
    rs_i = rs; rw_i = rw; db_i = v; en_i = 1'b1;
    repeat (6) @(negedge clk);
    r = db_o; last_oe = db_oe_o;
    en_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_byte(input logic rs, input logic [7:0] v);
    logic [7:0] r;
    if (nib_mode_i) begin
      xfer(rs, 1'b0, {v[7:4], ~v[3:0]}, r);
      xfer(rs, 1'b0, {v[3:0], v[7:4]}, r);
    end else xfer(rs, 1'b0, v, r);
  endtask

  task automatic rd_byte(input logic rs, output logic [7:0] v);
    logic [7:0] a, b;
    if (nib_mode_i) begin
      xfer(rs, 1'b1, 8'h00, a);
      xfer(rs, 1'b1, 8'h00, b);
      v = {a[7:4], b[7:4]};
      chk(a[3:0] == 4'h0 && b[3:0] == 4'h0, "R8 low lines", {a[3:0], b[3:0]}, 0);
    end else xfer(rs, 1'b1, 8'h00, v);
  endtask

  initial begin
    #(8 * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int b0, c0;
    repeat (3) @(negedge clk);
    chk(!db_oe_o && !busy_o && !instr_wr_o && !data_wr_o && !status_rd_o && !data_rd_o && !instr_err_o,
        "R1 reset outputs", {db_oe_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: 8-bit instruction writes, every byte
    for (int v = 0; v < 256; v++) begin
      c0 = n_iwr;
      wr_byte(1'b0, v[7:0]);
      chk(n_iwr == c0 + 1 && last_wr == v[7:0], "R2 instr write 8b", last_wr, v);
      chk(!db_oe_o && !last_oe, "R6 no drive on write", db_oe_o, 0);
    end
    // R4: status reads, every address, not busy
    for (int a = 0; a < 128; a++) begin
      ac_i = a[6:0]; c0 = n_stat;
      rd_byte(1'b0, r);
      chk(r == {1'b0, a[6:0]} && n_stat == c0 + 1, "R4 status 8b", r, a);
      chk(last_oe && !db_oe_o, "R6 drive only in read", {last_oe, db_oe_o}, 2);
    end
    // R5: data reads, every byte
    for (int v = 0; v < 256; v++) begin
      rd_data_i = v[7:0]; c0 = n_drd;
      rd_byte(1'b1, r);
      chk(r == v[7:0] && n_drd == c0 + 1, "R5 data read 8b", r, v);
    end

    // nibble mode
    nib_mode_i = 1'b1; repeat (3) @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      c0 = n_dwr;
      wr_byte(1'b1, v[7:0]);
      chk(n_dwr == c0 + 1 && last_wr == v[7:0], "R7 R3 data write 4b", last_wr, v);
    end
    for (int v = 0; v < 256; v++) begin
      c0 = n_iwr;
      wr_byte(1'b0, v[7:0]);
      chk(n_iwr == c0 + 1 && last_wr == v[7:0], "R7 instr write 4b", last_wr, v);
    end
    for (int v = 0; v < 256; v++) begin
      rd_data_i = v[7:0]; c0 = n_drd;
      rd_byte(1'b1, r);
      chk(r == v[7:0] && n_drd == c0 + 1, "R8 data read 4b", r, v);
    end
    for (int a = 0; a < 128; a += 5) begin
      ac_i = a[6:0]; c0 = n_stat;
      rd_byte(1'b0, r);
      chk(r == {1'b0, a[6:0]} && n_stat == c0 + 1, "R8 status 4b", r, a);
    end

    // R9: half byte, mode flip and back, then a fresh byte
    c0 = n_iwr;
    xfer(1'b0, 1'b0, 8'hE0, r);
    nib_mode_i = 1'b0; repeat (4) @(negedge clk);
    nib_mode_i = 1'b1; repeat (4) @(negedge clk);
    chk(n_iwr == c0, "R9 half byte no strobe", n_iwr - c0, 0);
    xfer(1'b0, 1'b0, 8'h3F, r);
    chk(n_iwr == c0, "R9 first nibble after reset", n_iwr - c0, 0);
    xfer(1'b0, 1'b0, 8'hC5, r);
    chk(n_iwr == c0 + 1 && last_wr == 8'h3C, "R9 phase restarted", last_wr, 8'h3C);

    // R12: enable held low
    c0 = n_iwr + n_dwr + n_stat + n_drd + n_err;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); rs_i = k[0]; rw_i = k[1]; db_i = k[7:0] * 8'd37;
    end
    repeat (6) @(negedge clk);
    chk(n_iwr + n_dwr + n_stat + n_drd + n_err == c0 && !db_oe_o, "R12 idle enable",
        n_iwr + n_dwr + n_stat + n_drd + n_err - c0, 0);

    // busy behaviour, 8-bit mode
    nib_mode_i = 1'b0; busy_len_i = 8'd40; ac_i = 7'h55;
    repeat (4) @(negedge clk);
    n_busy = 0; c0 = n_iwr; b0 = n_err;
    wr_byte(1'b0, 8'h01);
    chk(n_iwr == c0 + 1, "R2 write accepted", n_iwr - c0, 1);
    rd_byte(1'b0, r);
    chk(r == 8'hD5, "R4 busy flag in bit 7", r, 8'hD5);
    wr_byte(1'b0, 8'h02);
    chk(n_err == b0 + 1 && n_iwr == c0 + 1 && last_wr == 8'h01, "R11 rejected while busy", n_err - b0, 1);
    repeat (60) @(negedge clk);
    chk(n_busy == 40, "R10 R11 busy length", n_busy, 40);
    rd_byte(1'b0, r);
    chk(r == 8'h55, "R4 busy clear", r, 8'h55);
    // data write accepted while busy
    n_busy = 0; c0 = n_dwr; b0 = n_err;
    busy_len_i = 8'd25;
    repeat (2) @(negedge clk);
    wr_byte(1'b1, 8'hA7);
    wr_byte(1'b1, 8'h5C);
    chk(n_dwr == c0 + 2 && n_err == b0 && last_wr == 8'h5C, "R3 data write while busy", last_wr, 8'h5C);
    repeat (60) @(negedge clk);
    chk(!busy_o, "R10 busy ends", busy_o, 0);
    // length sweep
    for (int l = 0; l < 12; l++) begin
      busy_len_i = l[7:0]; repeat (2) @(negedge clk);
      n_busy = 0;
      wr_byte(1'b0, l[7:0]);
      repeat (20) @(negedge clk);
      chk(n_busy == l, "R10 busy length sweep", n_busy, l);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule